// File: doc/BRIEF.md
# GPIO Pin Mode Controller

This block holds the per-pin configuration for a bank of general-purpose pins (128 by default) and turns it into pad drive signals. Each pin is owned in two steps. A plain type bit first decides between the function multiplexer and the directly controlled paths. For a pin that is not given to the function multiplexer, a second owner bit picks either the GPIO logic or the I/O coprocessor. The block reports this ownership to the pin multiplexer on three one-hot-per-pin vectors. The block does not gate its pad outputs by ownership, because the multiplexer picks the owner.

Software reaches the block through a 32-bit word port. The write is synchronous, and the read data is a combinational function of the address. A 6-bit address selects a register group in `addr[5:3]` and a word inside that group in `addr[2:0]`. The per-pin bits for ownership, direction, output value, inversion and open-drain sit in masked registers. In these registers a control bit changes only when its companion mask bit is set in the same write. Pad inputs are inverted where requested, registered once, and read back as plain words.

Top module: `gpio_mode_ctrl`

## Requirements
- R1: After reset every pin is GPIO owned: type words read 0xFFFFFFFF, owner words read 0x0000FFFF and `gpioSel` is all ones. Direction, output, inversion and open-drain bits are all 0, so `padOe` is all zeros.
- R2: Group 0 (type) holds plain 32-bit words, with pin n at word n/32, bit n%32. A 0 bit gives the pin to the function multiplexer (`funcSel`=1). A write to a type word does not change `padOut` or `padOe`.
- R3: Group 1 (owner) places pin n at word n/16, bit n%16. The owner bit matters only when the type bit is 1: owner 0 sets `copSel` and owner 1 sets `gpioSel`. For every pin, exactly one of `funcSel`, `copSel` and `gpioSel` is 1.
- R4: Groups 1 to 6 are masked registers. `wrData[16+k]` enables the update of control bit k from `wrData[k]`, and bits without their mask bit keep their value. A read returns the control bits in [15:0] and zeros in [31:16].
- R5: Group 2 is output enable (1 = drive) and group 3 is output value. When open-drain is off, `padOe` follows the enable bit and `padOut` equals the output value XOR the output-inversion bit (group 5).
- R6: When the open-drain bit (group 6) is set, `padOut` is 0 and `padOe` is the enable bit AND NOT(output value XOR output inversion).
- R7: Group 7 words 0 to 3 return the pad inputs, with pin n at word n/32, bit n%32. Each bit is XORed with its input-inversion bit (group 4) and registered on the clock edge before the read.
- R8: Writes to group 7 and writes to type words at index 4 or above change no state.
- R9: The input-inversion, output-inversion and open-drain bits read back as they were written.
- R10: A read of an index that is not mapped returns 0. This covers type or input words at index 4 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the word port |
| addr | input | 6 | Group in [5:3], word index in [2:0] |
| wrData | input | 32 | Write data (mask half in [31:16] for masked groups) |
| rdData | output | 32 | Read data for `addr` |
| padIn | input | NUM_PINS | Pad input levels |
| padOut | output | NUM_PINS | GPIO output level towards the pads |
| padOe | output | NUM_PINS | GPIO pad drive enable |
| funcSel | output | NUM_PINS | Pin is owned by the function multiplexer |
| copSel | output | NUM_PINS | Pin is owned by the I/O coprocessor |
| gpioSel | output | NUM_PINS | Pin is owned by the GPIO logic |

## Verification
The bench writes masked words with mask halves that are partial and with mask halves that are zero. A register that ignored the mask would overwrite neighbouring pins, and one that decoded the mask at the wrong offset would leave the chosen bits unchanged. The bench gives one pin a type bit of 0 and a cleared owner bit. A design that evaluated the owner before the type would then report the coprocessor for a pin that the function multiplexer owns. Open-drain is checked with the inverted output both high and low, so a design that applied inversion after the open-drain gating would drive a high level or drop the low drive. The input check puts the inversion on a word other than word 0 and writes to the read-only and unmapped indices, so a wrong word select or a stray write shows up as changed read data.

// File: rtl/gmc_pkg.sv
package gmc_pkg;
  localparam int ADDR_W = 6;
  localparam int MASKED_FIELDS = 6;  // owner, oe, out, iinv, oinv, odrn

  typedef enum logic [2:0] {
    GRP_TYPE  = 3'd0,
    GRP_OWNER = 3'd1,
    GRP_OE    = 3'd2,
    GRP_OUT   = 3'd3,
    GRP_IINV  = 3'd4,
    GRP_OINV  = 3'd5,
    GRP_ODRN  = 3'd6,
    GRP_INPUT = 3'd7
  } grp_e;

  // Field slots inside the masked storage array.
  localparam int F_OWNER = 0;
  localparam int F_OE    = 1;
  localparam int F_OUT   = 2;
  localparam int F_IINV  = 3;
  localparam int F_OINV  = 4;
  localparam int F_ODRN  = 5;

  typedef struct packed {
    logic                     typeWr;
    logic [MASKED_FIELDS-1:0] fieldWr;
    logic [2:0]               idx;
    grp_e                     rdGrp;
    logic                     idxOk;
  } strobe_t;
endpackage

// File: rtl/gmc_mask_reg.sv
module gmc_mask_reg #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           we,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);
  logic [W-1:0] maskBits;
  logic [W-1:0] ctlBits;

  assign maskBits = wdata[2*W-1:W];
  assign ctlBits  = wdata[W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= RST;
    else if (we) q <= (q & ~maskBits) | (ctlBits & maskBits);
  end
endmodule

// File: rtl/gmc_ctrl.sv
module gmc_ctrl
  import gmc_pkg::*;
#(
  parameter int PLAIN_REGS  = 4,
  parameter int MASKED_REGS = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam logic [3:0] PLAIN_LIM  = 4'(PLAIN_REGS);
  localparam logic [3:0] MASKED_LIM = 4'(MASKED_REGS);

  grp_e       grp;
  logic [2:0] idx;
  logic       inRange;

  assign grp = grp_e'(addr[5:3]);
  assign idx = addr[2:0];

  always_comb begin
    if (grp == GRP_TYPE || grp == GRP_INPUT) inRange = {1'b0, idx} < PLAIN_LIM;
    else                                     inRange = {1'b0, idx} < MASKED_LIM;
  end

  always_comb begin
    stb       = '0;
    stb.idx   = idx;
    stb.rdGrp = grp;
    stb.idxOk = inRange;
    if (wrEn && inRange) begin
      case (grp)
        GRP_TYPE:  stb.typeWr           = 1'b1;
        GRP_OWNER: stb.fieldWr[F_OWNER] = 1'b1;
        GRP_OE:    stb.fieldWr[F_OE]    = 1'b1;
        GRP_OUT:   stb.fieldWr[F_OUT]   = 1'b1;
        GRP_IINV:  stb.fieldWr[F_IINV]  = 1'b1;
        GRP_OINV:  stb.fieldWr[F_OINV]  = 1'b1;
        GRP_ODRN:  stb.fieldWr[F_ODRN]  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gmc_datapath.sv
module gmc_datapath
  import gmc_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] funcSel,
  output logic [NUM_PINS-1:0] copSel,
  output logic [NUM_PINS-1:0] gpioSel,
  output logic [NUM_PINS-1:0] odBits
);
  localparam int PLAIN_REGS  = NUM_PINS / 32;
  localparam int MASKED_REGS = NUM_PINS / 16;
  localparam int PIDX_W      = $clog2(PLAIN_REGS);
  localparam int MIDX_W      = $clog2(MASKED_REGS);

  logic [31:0]                              typeW  [PLAIN_REGS];
  logic [15:0]                              fieldW [MASKED_FIELDS][MASKED_REGS];
  logic [NUM_PINS-1:0]                      typeV;
  logic [MASKED_FIELDS-1:0][NUM_PINS-1:0]   fieldV;
  logic [NUM_PINS-1:0]                      inQ;
  logic [NUM_PINS-1:0]                      outVal;

  genvar w, f, r;
  generate
    for (w = 0; w < PLAIN_REGS; w++) begin : g_type
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   typeW[w] <= '1;
        else if (stb.typeWr && stb.idx == 3'(w))     typeW[w] <= wrData;
      end
      assign typeV[w*32 +: 32] = typeW[w];
    end

    for (f = 0; f < MASKED_FIELDS; f++) begin : g_field
      for (r = 0; r < MASKED_REGS; r++) begin : g_reg
        gmc_mask_reg #(
          .W  (16),
          .RST((f == F_OWNER) ? 16'hFFFF : 16'h0000)
        ) u_reg (
          .clk  (clk),
          .rstN (rstN),
          .we   (stb.fieldWr[f] && stb.idx == 3'(r)),
          .wdata(wrData),
          .q    (fieldW[f][r])
        );
        assign fieldV[f][r*16 +: 16] = fieldW[f][r];
      end
    end
  endgenerate

  // Input path: inversion ahead of the sample register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inQ <= '0;
    else       inQ <= padIn ^ fieldV[F_IINV];
  end

  // Ownership: type bit first, owner bit second.
  assign funcSel = ~typeV;
  assign copSel  = typeV & ~fieldV[F_OWNER];
  assign gpioSel = typeV & fieldV[F_OWNER];

  // Output path: inversion after the output value register, then open-drain.
  assign outVal = fieldV[F_OUT] ^ fieldV[F_OINV];
  assign padOut = outVal & ~fieldV[F_ODRN];
  assign padOe  = fieldV[F_OE] & ~(fieldV[F_ODRN] & outVal);
  assign odBits = fieldV[F_ODRN];

  logic [2:0] fSel;
  assign fSel = 3'(stb.rdGrp) - 3'd1;

  always_comb begin
    rdData = '0;
    if (stb.idxOk) begin
      case (stb.rdGrp)
        GRP_TYPE:  rdData = typeW[stb.idx[PIDX_W-1:0]];
        GRP_INPUT: rdData = inQ[{stb.idx[PIDX_W-1:0], 5'b0} +: 32];
        default:   rdData = {16'h0, fieldW[fSel][stb.idx[MIDX_W-1:0]]};
      endcase
    end
  end
endmodule

// File: rtl/gpio_mode_ctrl.sv
module gpio_mode_ctrl
  import gmc_pkg::*;
#(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [5:0]          addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] funcSel,
  output logic [NUM_PINS-1:0] copSel,
  output logic [NUM_PINS-1:0] gpioSel
);
  localparam int PLAIN_REGS  = NUM_PINS / 32;
  localparam int MASKED_REGS = NUM_PINS / 16;

  strobe_t             stb;
  logic [NUM_PINS-1:0] odQ;

  gmc_ctrl #(
    .PLAIN_REGS (PLAIN_REGS),
    .MASKED_REGS(MASKED_REGS)
  ) ctrl_i (
    .wrEn(wrEn),
    .addr(addr),
    .stb (stb)
  );

  gmc_datapath #(
    .NUM_PINS(NUM_PINS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .rdData (rdData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .funcSel(funcSel),
    .copSel (copSel),
    .gpioSel(gpioSel),
    .odBits (odQ)
  );
endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
  parameter int NUM_PINS = 128
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [5:0]          addr,
  input logic [31:0]         wrData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] funcSel,
  input logic [NUM_PINS-1:0] copSel,
  input logic [NUM_PINS-1:0] gpioSel,
  input logic [NUM_PINS-1:0] odBits
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0 && gpioSel == '1));

  p_owner_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((funcSel | copSel | gpioSel) == '1) &&
    (((funcSel & copSel) | (funcSel & gpioSel) | (copSel & gpioSel)) == '0));

  p_type_keeps_pads_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[5:3] == 3'd0) |=> ($stable(padOut) && $stable(padOe)));

  p_nomask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[5:3] == 3'd2 && wrData[31:16] == 16'h0) |=> $stable(padOe));

  p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (odBits & padOut) == '0);

  p_input_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[5:3] == 3'd7) |=>
      ($stable(funcSel) && $stable(copSel) && $stable(padOut) && $stable(padOe)));
endmodule

bind gpio_mode_ctrl gmc_checker #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .padOut (padOut),
  .padOe  (padOe),
  .funcSel(funcSel),
  .copSel (copSel),
  .gpioSel(gpioSel),
  .odBits (odQ)
);

// File: tb/gpio_mode_ctrl_tb.sv
module gpio_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [5:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, funcSel, copSel, gpioSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mode_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .funcSel(funcSel), .copSel(copSel), .gpioSel(gpioSel)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    #1;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, {96'h0, rdData}, {96'h0, exp});
  endtask

  task automatic test_reset();
    rdChk("R1 type word", 6'd0, 32'hFFFF_FFFF);
    rdChk("R1 owner word", 6'd8, 32'h0000_FFFF);
    rdChk("R1 odrn word", 6'd55, 32'h0);
    rdChk("R1 iinv word", 6'd32, 32'h0);
    check("R1 padOe", padOe, '0);
    check("R1 gpioSel", gpioSel, '1);
  endtask

  task automatic test_type();
    wr(6'd1, 32'hFFFF_FFFE);
    check("R2 funcSel", funcSel, NP'(1) << 32);
    check("R2 gpioSel", gpioSel, ~(NP'(1) << 32));
    rdChk("R2 readback", 6'd1, 32'hFFFF_FFFE);
  endtask

  task automatic test_owner();
    wr(6'd10, 32'h0003_0000);
    check("R3 copSel", copSel, NP'(1) << 33);
    check("R3 funcSel wins", funcSel, NP'(1) << 32);
    rdChk("R3 readback", 6'd10, 32'h0000_FFFC);
  endtask

  task automatic test_mask();
    wr(6'd16, 32'h00FF_FFFF);
    rdChk("R4 partial mask", 6'd16, 32'h0000_00FF);
    check("R4 padOe", padOe, NP'(8'hFF));
    wr(6'd16, 32'h0000_FF00);
    rdChk("R4 empty mask", 6'd16, 32'h0000_00FF);
    check("R4 padOe held", padOe, NP'(8'hFF));
  endtask

  task automatic test_out();
    wr(6'd24, 32'h000F_0005);
    check("R5 padOut", padOut, NP'(4'h5));
    check("R5 padOe", padOe, NP'(8'hFF));
    wr(6'd40, 32'h0003_0003);
    check("R5 inverted padOut", padOut, NP'(4'h6));
    rdChk("R9 oinv readback", 6'd40, 32'h0000_0003);
  endtask

  task automatic test_od();
    wr(6'd48, 32'h000F_000F);
    check("R6 padOut low", padOut, '0);
    check("R6 padOe", padOe, NP'(8'hF9));
    rdChk("R9 odrn readback", 6'd48, 32'h0000_000F);
    wr(6'd48, 32'h0002_0000);
    check("R6 partial padOut", padOut, NP'(4'h2));
    check("R6 partial padOe", padOe, NP'(8'hFB));
  endtask

  task automatic test_input();
    @(negedge clk);
    padIn = {32'hA5A5_0F0F, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_F00D};
    wr(6'd36, 32'h00FF_00FF);
    @(posedge clk);
    rdChk("R7 inverted word", 6'd58, 32'h1234_5687);
    rdChk("R7 plain word", 6'd56, 32'hCAFE_F00D);
    rdChk("R7 top word", 6'd59, 32'hA5A5_0F0F);
    rdChk("R9 iinv readback", 6'd36, 32'h0000_00FF);
  endtask

  task automatic test_ignored();
    wr(6'd56, 32'h0000_0000);
    rdChk("R8 input write", 6'd56, 32'hCAFE_F00D);
    wr(6'd4, 32'h0000_0000);
    rdChk("R8 type word1", 6'd1, 32'hFFFF_FFFE);
    rdChk("R8 type word3", 6'd3, 32'hFFFF_FFFF);
    check("R8 funcSel", funcSel, NP'(1) << 32);
    rdChk("R10 type idx4", 6'd4, 32'h0);
    rdChk("R10 input idx4", 6'd60, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    test_reset();
    test_type();
    test_owner();
    test_mask();
    test_out();
    test_od();
    test_input();
    test_ignored();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule